// File: doc/BRIEF.md
# Synchronous Programmable One-Shot

This block turns a rising edge on a trigger wire into one clean, active-high pulse whose width is set in whole clock periods by an N-bit delay input. The trigger may come from anywhere and need not be aligned to the clock. It is brought into the clock domain by a short flip-flop chain before any other logic sees it, and a registered previous-value stage turns the synchronised level into a one-cycle edge strobe.

On that strobe a control state machine has the datapath load a down-counter from the delay input. The pulse stays high while the counter runs down. It ends when the counter equals zero, so the terminal test compares against a constant and never against the live delay input. The one-shot cannot be retriggered. The delay input is read only on the load cycle. Reset is asynchronous and active high, and it is used only for start-up.

Top module: `pulse_oneshot`

## Requirements
- R1: While reset is asserted, and afterwards until a trigger edge is accepted, the pulse output is low.
- R2: A trigger rise driven between clock edges makes the output go high on the third rising clock edge after it: two synchroniser stages, then the state register. The latency is fixed.
- R3: For a delay value D in 1 to 2^N-1, the output stays high for exactly D clock periods and then returns low.
- R4: A delay value of zero on the load cycle gives no pulse. The output stays low.
- R5: Trigger edges that arrive while a pulse is high are ignored. The pulse width is unchanged and no second pulse follows.
- R6: The delay input is sampled only on the cycle that accepts the trigger edge. Changing it during a pulse does not alter that pulse's width.
- R7: A trigger held high after a pulse ends does not start another pulse. Only a new low-to-high transition does.
- R8: Once the output has returned low and the trigger has been low for at least three clocks, a new trigger rise starts a new pulse with the same latency as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst | input | 1 | Asynchronous start-up reset, active high |
| trigAsync | input | 1 | Unsynchronised trigger; its rising edge starts a pulse |
| delayIn | input | DELAY_W (8) | Pulse width in clock periods; zero suppresses the pulse |
| pulseOut | output | 1 | Active-high one-shot output |

## Verification
The hardest case to reach from the ports is a trigger edge that lands inside an active pulse, close enough to matter but far enough from the end to test non-retriggering rather than re-arming. It is made harder because the edge only reaches the controller three clocks after it is driven. The stimulus reaches it by driving the trigger on falling clock edges at known offsets into the measured high time. It drops and re-raises the trigger a few cycles into pulses of ten clocks or more, and changes the delay input in the middle of a pulse. Random delay values from a fixed seed are mixed with the extremes 0, 1 and 255, and each width and latency is compared with the value computed in the bench.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // strobes from the controller to the counter datapath
  typedef struct packed {
    logic loadCount;   // capture delayIn-1 into the counter
    logic decCount;    // count down by one
  } ctrlStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } oneshotState_t;

endpackage

// File: rtl/trig_sync.sv
// Brings an asynchronous level into the clock domain and flags its rising edge.
module trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trigAsync,
  output logic trigRise
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLevel;

  // only syncChain[0] sees the raw input
  always_ff @(posedge clk or posedge rst) begin
    if (rst) syncChain[0] <= 1'b0;
    else     syncChain[0] <= trigAsync;
  end

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
        if (rst) syncChain[g] <= 1'b0;
        else     syncChain[g] <= syncChain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) prevLevel <= 1'b0;
    else     prevLevel <= syncChain[SYNC_STAGES-1];
  end

  assign trigRise = syncChain[SYNC_STAGES-1] & ~prevLevel;

endmodule

// File: rtl/pulse_ctrl.sv
// Two-state controller: waits for an accepted edge, then runs until the counter is empty.
module pulse_ctrl
  import oneshot_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         trigRise,
  input  logic         delayIsZero,
  input  logic         countIsZero,
  output ctrlStrobes_t strobes,
  output logic         pulseActive
);

  oneshotState_t state, stateNext;

  always_comb begin
    stateNext         = state;
    strobes.loadCount = 1'b0;
    strobes.decCount  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (trigRise && !delayIsZero) begin
          strobes.loadCount = 1'b1;
          stateNext         = ST_BUSY;
        end
      end
      ST_BUSY: begin
        // edges seen here are dropped: not retriggerable
        if (countIsZero) stateNext = ST_IDLE;
        else             strobes.decCount = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign pulseActive = (state == ST_BUSY);

endmodule

// File: rtl/pulse_datapath.sv
// Down-counter loaded with delay-1; the terminal test is against constant zero.
module pulse_datapath
  import oneshot_pkg::*;
#(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [DELAY_W-1:0] delayIn,
  output logic               delayIsZero,
  output logic               countIsZero,
  output logic [DELAY_W-1:0] countVal
);

  localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

  logic [DELAY_W-1:0] countReg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                    countReg <= '0;
    else if (strobes.loadCount) countReg <= delayIn - ONE;
    else if (strobes.decCount)  countReg <= countReg - ONE;
  end

  assign delayIsZero = (delayIn == '0);
  assign countIsZero = (countReg == '0);
  assign countVal    = countReg;

endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot
  import oneshot_pkg::*;
#(
  parameter int DELAY_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trigAsync,
  input  logic [DELAY_W-1:0] delayIn,
  output logic               pulseOut
);

  logic               trigRise;
  logic               delayIsZero;
  logic               countIsZero;
  logic [DELAY_W-1:0] countVal;
  ctrlStrobes_t       strobes;

  trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .trigAsync (trigAsync),
    .trigRise  (trigRise)
  );

  pulse_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .trigRise    (trigRise),
    .delayIsZero (delayIsZero),
    .countIsZero (countIsZero),
    .strobes     (strobes),
    .pulseActive (pulseOut)
  );

  pulse_datapath #(.DELAY_W(DELAY_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .delayIn     (delayIn),
    .delayIsZero (delayIsZero),
    .countIsZero (countIsZero),
    .countVal    (countVal)
  );

endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker #(
  parameter int DELAY_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               trigRise,
  input logic [DELAY_W-1:0] delayIn,
  input logic [DELAY_W-1:0] countVal,
  input logic               pulseOut
);

  // R1: output cleared by reset
  p_reset_low_r1: assert property (@(posedge clk) rst |=> !pulseOut);

  // R2: output only rises after a synchronised edge
  p_rise_from_edge_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pulseOut) |-> $past(trigRise));

  // R3: the pulse ends the cycle after the counter reaches zero
  p_end_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (pulseOut && countVal == '0) |=> !pulseOut);

  // R4: a zero delay never starts a pulse
  p_zero_nopulse_r4: assert property (@(posedge clk) disable iff (rst)
    (!pulseOut && trigRise && delayIn == '0) |=> !pulseOut);

  // R5: while running, the count only steps down by one, whatever the trigger does
  p_no_retrigger_r5: assert property (@(posedge clk) disable iff (rst)
    (pulseOut && countVal != '0) |=> (pulseOut && countVal == $past(countVal) - 1'b1));

  // R6: the load captures the delay presented on the accept cycle
  p_load_delay_r6: assert property (@(posedge clk) disable iff (rst)
    (!pulseOut && trigRise && delayIn != '0) |=> (pulseOut && countVal == $past(delayIn) - 1'b1));

endmodule

bind pulse_oneshot oneshot_checker #(.DELAY_W(DELAY_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .trigRise (trigRise),
  .delayIn  (delayIn),
  .countVal (countVal),
  .pulseOut (pulseOut)
);

// File: tb/test_pulse_oneshot.sv
`timescale 1ns/1ps
module test_pulse_oneshot;

  localparam int DELAY_W = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               trigAsync = 1'b0;
  logic [DELAY_W-1:0] delayIn = '0;
  logic               pulseOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pulse_oneshot #(.DELAY_W(DELAY_W)) i_pulse_oneshot (
    .clk       (clk),
    .rst       (rst),
    .trigAsync (trigAsync),
    .delayIn   (delayIn),
    .pulseOut  (pulseOut)
  );

  function automatic int expWidth(input int d);
    return d;
  endfunction

  function automatic int expLatency();
    return 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Fire one trigger and measure latency and width at falling edges.
  task automatic runPulse(input int d, input bit retrig, input bit changeDelay);
    int lat = 0;
    int hi  = 0;
    @(negedge clk);
    delayIn   = DELAY_W'(d);
    trigAsync = 1'b1;
    if (d == 0) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (pulseOut) hi++;
      end
      check(hi == 0, "R4 zero delay", hi, 0);
    end else begin
      while (!pulseOut && lat < 10) begin
        @(negedge clk);
        lat++;
      end
      check(lat == expLatency(), (d % 2 == 0) ? "R2 latency" : "R8 re-arm latency", lat, expLatency());
      while (pulseOut && hi < 400) begin
        hi++;
        if (retrig && hi == 2) trigAsync = 1'b0;
        if (retrig && hi == 4) trigAsync = 1'b1;
        if (changeDelay && hi == 3) delayIn = DELAY_W'($urandom_range(1, 255));
        @(negedge clk);
      end
      if (retrig)           check(hi == expWidth(d), "R5 retrigger ignored", hi, expWidth(d));
      else if (changeDelay) check(hi == expWidth(d), "R6 delay change mid-pulse", hi, expWidth(d));
      else                  check(hi == expWidth(d), "R3 width", hi, expWidth(d));
      // trigger still high: no second pulse
      hi = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (pulseOut) hi++;
      end
      check(hi == 0, "R7 held trigger", hi, 0);
    end
    trigAsync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int lowSeen = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(pulseOut == 1'b0, "R1 reset low", int'(pulseOut), 0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pulseOut) lowSeen++;
    end
    check(lowSeen == 0, "R1 idle after reset", lowSeen, 0);

    runPulse(1, 1'b0, 1'b0);
    runPulse(2, 1'b0, 1'b0);
    runPulse(255, 1'b0, 1'b0);
    runPulse(0, 1'b0, 1'b0);
    runPulse(20, 1'b1, 1'b0);
    runPulse(12, 1'b0, 1'b1);
    runPulse(7, 1'b0, 1'b0);

    for (int n = 0; n < 40; n++) begin
      int r = $urandom_range(0, 9);
      int d = (r == 0) ? 0 : $urandom_range(1, 255);
      runPulse(d, (d >= 10) && (r == 3), (d >= 6) && (r == 5));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule